// File: doc/BRIEF.md
# Vectored Interrupt Pending Controller

This block collects up to 32 peripheral request lines. It keeps an enable bit, a pending bit and a priority level for each line. Among the lines that are both pending and enabled, it selects the one with the best priority and offers that line's number to the core through a request/acknowledge pair. A one-cycle pulse on a request line is latched as pending, so a peripheral does not have to hold its request. When the core acknowledges a line, the controller drops that line's pending bit.

Software reaches the block through a small register bus that supports byte, halfword and word transfers.

- Enable bits and pending bits each have a write-one-to-set address and a write-one-to-clear address, so a handler never needs a read-modify-write.
- Priority levels are packed one byte per line. Only the upper `PRIO_BITS` of each byte exist.
- A trigger register pends a line given its number. When the access is unprivileged, this register works only if a configuration bit allows it.

Top module: `irq_pend_ctrl`

## Requirements
- R1: A write to EN_SET (byte offset 0x00) sets each enable bit whose data bit is 1. A write to EN_CLR (0x04) clears each enable bit whose data bit is 1. Data bits of 0 leave enables unchanged. Reading either address returns the enable vector, with line n at bit n.
- R2: PEND_SET (0x08) and PEND_CLR (0x0C) act on the pending vector in the same way. A clear and a set of the same bit in one cycle leave the bit clear.
- R3: A request input that is high for one clock cycle sets that line's pending bit at the same edge. The bit stays set after the input falls.
- R4: At a clock edge where `irq_ack` and `irq_req` are both high, the pending bit of line `irq_id` is cleared. If that line's request input is still high, the bit is set again at the following edge.
- R5: `irq_req` is high exactly when at least one line is both pending and enabled. `irq_id` names the eligible line with the numerically lowest priority value; on a tie, the lower line number wins. With no eligible line, `irq_id` is 0. Both outputs follow the state without added delay.
- R6: Priority bytes start at offset 0x40, with line n in byte n. On the bus, byte lane k carries `bus_wdata[8k+7:8k]`. `bus_size` selects the transfer: 0 is a byte at lane `bus_addr[1:0]`, 1 is a halfword at lanes 0–1 or 2–3 chosen by `bus_addr[1]`, and 2 is a word. A transfer changes only the bytes it covers.
- R7: Each priority byte keeps only its upper `PRIO_BITS` bits; the lower bits read as 0. With `PRIO_BITS`=3, writing 0xFF reads back 0xE0.
- R8: After reset, all enables, pending bits, priorities and the configuration bit are 0, and `irq_req` is low.
- R9: A write to TRIG (0x10) with line number m in `bus_wdata[7:0]` sets pending bit m when m < `NUM_LINES`. If m is out of range, the write changes nothing.
- R10: A TRIG write with `bus_priv`=0 takes effect only when bit 0 of CFG (0x14) is 1; otherwise it is ignored. A TRIG write with `bus_priv`=1 always takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Register access this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_priv | input | 1 | 1 = privileged access |
| bus_addr | input | ADDR_W | Byte address |
| bus_size | input | 2 | 0 byte, 1 halfword, 2 word |
| bus_wdata | input | 32 | Write data on byte lanes |
| bus_rdata | output | 32 | Read data, same cycle |
| req_in | input | NUM_LINES | Peripheral request lines |
| irq_req | output | 1 | An eligible line exists |
| irq_id | output | ID_W | Number of the selected line |
| irq_ack | input | 1 | Core takes the offered line |

## Verification
The bench writes priority bytes through single-byte, halfword and word transfers, then reads back whole words. A lane decoder that is off by one would corrupt a neighbouring line's level, and a design that kept all eight bits would return unmasked bytes.

It creates a priority tie between two pending, enabled lines and checks the selected line number. An arbiter with the wrong comparison direction would pick the higher line number.

It acknowledges a line while another line stays pending and a request input is still held high. Clearing the wrong bit, or losing the level request, would show up in the pending vector read back afterwards.

Trigger writes are tried with a number out of range, unprivileged with the configuration bit at 0, and then unprivileged with the bit at 1. A missing range or privilege gate would pend extra lines.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

   // word indices inside the register window (byte offset / 4)
   localparam int unsigned WI_EN_SET    = 0;
   localparam int unsigned WI_EN_CLR    = 1;
   localparam int unsigned WI_PD_SET    = 2;
   localparam int unsigned WI_PD_CLR    = 3;
   localparam int unsigned WI_TRIG      = 4;
   localparam int unsigned WI_CFG       = 5;
   localparam int unsigned WI_PRIO_BASE = 16;

   localparam logic [1:0] SZ_BYTE = 2'd0;
   localparam logic [1:0] SZ_HALF = 2'd1;

   // byte lanes touched by one transfer
   function automatic logic [3:0] lane_mask(input logic [1:0] sz, input logic [1:0] lane);
      if (sz == SZ_BYTE)      return 4'b0001 << lane;
      else if (sz == SZ_HALF) return lane[1] ? 4'b1100 : 4'b0011;
      else                    return 4'b1111;
   endfunction

endpackage

// File: rtl/irqc_regbus.sv
module irqc_regbus
   import irqc_pkg::*;
#(
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned NUM_LINES = 32,
   parameter int unsigned PIDX_W    = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bus_valid,
   input  logic                 bus_write,
   input  logic                 bus_priv,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic [1:0]           bus_size,
   input  logic [31:0]          bus_wdata,
   output logic [31:0]          bus_rdata,
   input  logic [NUM_LINES-1:0] en_vec,
   input  logic [NUM_LINES-1:0] pend_vec,
   input  logic [31:0]          prio_rd_word,
   output logic [NUM_LINES-1:0] en_set_m,
   output logic [NUM_LINES-1:0] en_clr_m,
   output logic [NUM_LINES-1:0] pd_set_m,
   output logic [NUM_LINES-1:0] pd_clr_m,
   output logic                 prio_wr,
   output logic [PIDX_W-1:0]    prio_idx,
   output logic [3:0]           byte_en,
   output logic [31:0]          wdata_m
);

   localparam int unsigned WW         = ADDR_W - 2;
   localparam int unsigned PRIO_WORDS = (NUM_LINES + 3) / 4;
   localparam logic [WW-1:0] PBASE    = WW'(WI_PRIO_BASE);

   logic [WW-1:0] word;
   logic          wr, rd, prio_hit, trig_ok, trig_hit, user_trig_q;
   logic [7:0]    trig_num;

   assign word     = bus_addr[ADDR_W-1:2];
   assign wr       = bus_valid && bus_write;
   assign rd       = bus_valid && !bus_write;
   assign byte_en  = lane_mask(bus_size, bus_addr[1:0]);
   assign wdata_m  = bus_wdata & {{8{byte_en[3]}}, {8{byte_en[2]}}, {8{byte_en[1]}}, {8{byte_en[0]}}};
   assign prio_hit = (word >= PBASE) && (word < PBASE + WW'(PRIO_WORDS));
   assign prio_idx = PIDX_W'(word - PBASE);
   assign prio_wr  = wr && prio_hit;

   assign en_set_m = (wr && word == WW'(WI_EN_SET)) ? wdata_m[NUM_LINES-1:0] : '0;
   assign en_clr_m = (wr && word == WW'(WI_EN_CLR)) ? wdata_m[NUM_LINES-1:0] : '0;
   assign pd_clr_m = (wr && word == WW'(WI_PD_CLR)) ? wdata_m[NUM_LINES-1:0] : '0;

   // software trigger: privileged always, unprivileged only when allowed
   assign trig_num = bus_wdata[7:0];
   assign trig_ok  = bus_priv || user_trig_q;
   assign trig_hit = wr && (word == WW'(WI_TRIG)) && trig_ok;

   always_comb begin
      pd_set_m = (wr && word == WW'(WI_PD_SET)) ? wdata_m[NUM_LINES-1:0] : '0;
      for (int i = 0; i < NUM_LINES; i++)
         if (trig_hit && trig_num == 8'(i)) pd_set_m[i] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                     user_trig_q <= 1'b0;
      else if (wr && word == WW'(WI_CFG) && byte_en[0]) user_trig_q <= bus_wdata[0];
   end

   always_comb begin
      logic [31:0] en_w, pd_w;
      en_w = '0;
      pd_w = '0;
      en_w[NUM_LINES-1:0] = en_vec;
      pd_w[NUM_LINES-1:0] = pend_vec;
      bus_rdata = '0;
      if (rd) begin
         if (word == WW'(WI_EN_SET) || word == WW'(WI_EN_CLR))      bus_rdata = en_w;
         else if (word == WW'(WI_PD_SET) || word == WW'(WI_PD_CLR)) bus_rdata = pd_w;
         else if (word == WW'(WI_CFG))                              bus_rdata = {31'd0, user_trig_q};
         else if (prio_hit)                                         bus_rdata = prio_rd_word;
      end
   end

endmodule

// File: rtl/irqc_prio_bank.sv
module irqc_prio_bank #(
   parameter int unsigned NUM_LINES = 32,
   parameter int unsigned PRIO_BITS = 3,
   parameter int unsigned PIDX_W    = 3
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           wr_en,
   input  logic [PIDX_W-1:0]              idx,
   input  logic [3:0]                     byte_en,
   input  logic [31:0]                    wdata,
   output logic [NUM_LINES*PRIO_BITS-1:0] prio_flat,
   output logic [31:0]                    rd_word
);

   logic [7:0] prio_byte [NUM_LINES];
   logic       unused_low;

   assign unused_low = ^wdata;

   for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
      localparam int unsigned W = g / 4;
      localparam int unsigned L = g % 4;
      logic [PRIO_BITS-1:0] lvl_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            lvl_q <= '0;
         else if (wr_en && idx == PIDX_W'(W) && byte_en[L])
            lvl_q <= wdata[8*L+7 -: PRIO_BITS];
      end

      assign prio_flat[g*PRIO_BITS +: PRIO_BITS] = lvl_q;

      if (PRIO_BITS == 8) begin : g_full
         assign prio_byte[g] = lvl_q;
      end else begin : g_trunc
         assign prio_byte[g] = {lvl_q, {(8-PRIO_BITS){1'b0}}};
      end
   end

   always_comb begin
      rd_word = '0;
      for (int i = 0; i < NUM_LINES; i++)
         if (idx == PIDX_W'(i / 4)) rd_word[8*(i%4) +: 8] = prio_byte[i];
   end

endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter #(
   parameter int unsigned NUM_LINES = 32,
   parameter int unsigned PRIO_BITS = 3,
   parameter int unsigned ID_W      = 5
) (
   input  logic [NUM_LINES-1:0]           eligible,
   input  logic [NUM_LINES*PRIO_BITS-1:0] prio_flat,
   output logic                           win_valid,
   output logic [ID_W-1:0]                win_id
);

   // scan upward; strict less-than keeps the lower number on a tie
   always_comb begin
      logic [PRIO_BITS-1:0] best;
      logic                 found;
      found  = 1'b0;
      best   = '0;
      win_id = '0;
      for (int i = 0; i < NUM_LINES; i++) begin
         if (eligible[i] && (!found || prio_flat[i*PRIO_BITS +: PRIO_BITS] < best)) begin
            found  = 1'b1;
            best   = prio_flat[i*PRIO_BITS +: PRIO_BITS];
            win_id = ID_W'(i);
         end
      end
      win_valid = found;
   end

endmodule

// File: rtl/irq_pend_ctrl.sv
module irq_pend_ctrl #(
   parameter int unsigned NUM_LINES = 32,
   parameter int unsigned PRIO_BITS = 3,
   parameter int unsigned ADDR_W    = 8,
   localparam int unsigned ID_W     = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
   localparam int unsigned PWORDS   = (NUM_LINES + 3) / 4,
   localparam int unsigned PIDX_W   = (PWORDS > 1) ? $clog2(PWORDS) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bus_valid,
   input  logic                 bus_write,
   input  logic                 bus_priv,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic [1:0]           bus_size,
   input  logic [31:0]          bus_wdata,
   output logic [31:0]          bus_rdata,
   input  logic [NUM_LINES-1:0] req_in,
   output logic                 irq_req,
   output logic [ID_W-1:0]      irq_id,
   input  logic                 irq_ack
);

   if (PRIO_BITS < 3 || PRIO_BITS > 8) begin : g_bad_prio
      $error("PRIO_BITS must lie in 3..8");
   end
   if (NUM_LINES < 1 || NUM_LINES > 32) begin : g_bad_lines
      $error("NUM_LINES must lie in 1..32");
   end
   if (ADDR_W < 7) begin : g_bad_addr
      $error("ADDR_W too small for the register window");
   end

   logic [NUM_LINES-1:0]           en_q, pend_q, ack_m;
   logic [NUM_LINES-1:0]           en_set_m, en_clr_m, pd_set_m, pd_clr_m;
   logic                           prio_wr;
   logic [PIDX_W-1:0]              prio_idx;
   logic [3:0]                     byte_en;
   logic [31:0]                    wdata_m, prio_rd_word;
   logic [NUM_LINES*PRIO_BITS-1:0] prio_flat;

   irqc_regbus #(.ADDR_W(ADDR_W), .NUM_LINES(NUM_LINES), .PIDX_W(PIDX_W)) u_regbus (
      .clk(clk), .rst_n(rst_n),
      .bus_valid(bus_valid), .bus_write(bus_write), .bus_priv(bus_priv),
      .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata),
      .en_vec(en_q), .pend_vec(pend_q), .prio_rd_word(prio_rd_word),
      .en_set_m(en_set_m), .en_clr_m(en_clr_m),
      .pd_set_m(pd_set_m), .pd_clr_m(pd_clr_m),
      .prio_wr(prio_wr), .prio_idx(prio_idx), .byte_en(byte_en), .wdata_m(wdata_m)
   );

   irqc_prio_bank #(.NUM_LINES(NUM_LINES), .PRIO_BITS(PRIO_BITS), .PIDX_W(PIDX_W)) u_prio (
      .clk(clk), .rst_n(rst_n),
      .wr_en(prio_wr), .idx(prio_idx), .byte_en(byte_en), .wdata(wdata_m),
      .prio_flat(prio_flat), .rd_word(prio_rd_word)
   );

   irqc_arbiter #(.NUM_LINES(NUM_LINES), .PRIO_BITS(PRIO_BITS), .ID_W(ID_W)) u_arb (
      .eligible(pend_q & en_q), .prio_flat(prio_flat),
      .win_valid(irq_req), .win_id(irq_id)
   );

   always_comb begin
      ack_m = '0;
      if (irq_ack && irq_req) ack_m[irq_id] = 1'b1;
   end

   // clears win over sets in the same cycle; a held request re-pends next edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= '0;
         pend_q <= '0;
      end else begin
         en_q   <= (en_q | en_set_m) & ~en_clr_m;
         pend_q <= (pend_q | req_in | pd_set_m) & ~pd_clr_m & ~ack_m;
      end
   end

endmodule

// File: rtl/irq_pend_ctrl_chk.sv
module irq_pend_ctrl_chk #(
   parameter int unsigned NUM_LINES = 32,
   parameter int unsigned ID_W      = 5
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 bus_valid,
   input logic                 bus_write,
   input logic [NUM_LINES-1:0] req_in,
   input logic                 irq_req,
   input logic [ID_W-1:0]      irq_id,
   input logic                 irq_ack,
   input logic [NUM_LINES-1:0] en_q,
   input logic [NUM_LINES-1:0] pend_q,
   input logic [NUM_LINES-1:0] pd_clr_m
);

   assert_req_eligible_R5: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req == (|(pend_q & en_q)));

   assert_id_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> (pend_q[irq_id] && en_q[irq_id]));

   assert_ack_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ack && irq_req) |=> !pend_q[$past(irq_id)]);

   assert_pulse_latched_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!(irq_ack && irq_req) && pd_clr_m == '0) |=> ((pend_q & $past(req_in)) == $past(req_in)));

   assert_enable_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_valid && bus_write) |=> $stable(en_q));

endmodule

bind irq_pend_ctrl irq_pend_ctrl_chk #(.NUM_LINES(NUM_LINES), .ID_W(ID_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
   .req_in(req_in), .irq_req(irq_req), .irq_id(irq_id), .irq_ack(irq_ack),
   .en_q(en_q), .pend_q(pend_q), .pd_clr_m(pd_clr_m)
);

// File: tb/irq_pend_ctrl_tb.sv
module irq_pend_ctrl_tb;

   localparam int NL = 32;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_valid = 1'b0, bus_write = 1'b0, bus_priv = 1'b1;
   logic [7:0]  bus_addr = '0;
   logic [1:0]  bus_size = 2'd2;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [NL-1:0] req_in = '0;
   logic        irq_req;
   logic [4:0]  irq_id;
   logic        irq_ack = 1'b0;

   always #10 clk = ~clk;

   irq_pend_ctrl #(.NUM_LINES(NL), .PRIO_BITS(3), .ADDR_W(8)) u_dut (
      .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
      .bus_priv(bus_priv), .bus_addr(bus_addr), .bus_size(bus_size),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .req_in(req_in),
      .irq_req(irq_req), .irq_id(irq_id), .irq_ack(irq_ack)
   );

   typedef struct {
      bit          is_irq;
      logic [31:0] exp;
      string       tag;
   } item_t;

   item_t q[$];
   logic  mon_go = 1'b0;
   int    n_chk = 0, n_fail = 0;
   bit    done = 0;

   // monitor: pops expected items and compares after the edge settles
   always @(posedge clk) begin
      #2;
      if (mon_go && q.size() > 0) begin
         item_t it;
         logic [31:0] act;
         it  = q.pop_front();
         act = it.is_irq ? {23'd0, irq_req, 3'd0, irq_id} : bus_rdata;
         n_chk++;
         if (act !== it.exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
         end
      end
   end

   task automatic do_wr(input logic [7:0] a, input logic [1:0] sz, input logic [31:0] d,
                        input logic priv = 1'b1);
      @(negedge clk);
      bus_valid = 1; bus_write = 1; bus_addr = a; bus_size = sz; bus_wdata = d; bus_priv = priv;
      @(negedge clk);
      bus_valid = 0; bus_write = 0; bus_priv = 1;
   endtask

   task automatic exp_rd(input logic [7:0] a, input logic [31:0] e, input string tag);
      item_t it;
      @(negedge clk);
      bus_valid = 1; bus_write = 0; bus_addr = a; bus_size = 2'd2;
      it.is_irq = 0; it.exp = e; it.tag = tag;
      q.push_back(it);
      mon_go = 1;
      @(negedge clk);
      mon_go = 0; bus_valid = 0;
   endtask

   task automatic exp_irq(input logic r, input logic [4:0] id, input string tag);
      item_t it;
      @(negedge clk);
      it.is_irq = 1; it.exp = {23'd0, r, 3'd0, id}; it.tag = tag;
      q.push_back(it);
      mon_go = 1;
      @(negedge clk);
      mon_go = 0;
   endtask

   task automatic ack_once();
      @(negedge clk);
      irq_ack = 1;
      @(negedge clk);
      irq_ack = 0;
   endtask

   task automatic finish_run();
      if (q.size() != 0) begin
         n_fail++;
         $display("FAIL scoreboard: actual %0d items left expected 0", q.size());
      end
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;

      // R8 reset state
      exp_rd(8'h00, 32'h0, "R8 enables");
      exp_rd(8'h08, 32'h0, "R8 pending");
      exp_rd(8'h40, 32'h0, "R8 priorities");
      exp_rd(8'h14, 32'h0, "R8 cfg");
      exp_irq(1'b0, 5'd0, "R8 no request");

      // R1 enable set/clear
      do_wr(8'h00, 2'd2, 32'h0000_00F0);
      exp_rd(8'h04, 32'h0000_00F0, "R1 set via EN_SET, read EN_CLR");
      do_wr(8'h00, 2'd2, 32'h0000_0001);
      exp_rd(8'h00, 32'h0000_00F1, "R1 zeros keep other enables");
      do_wr(8'h04, 2'd2, 32'h0000_0010);
      exp_rd(8'h00, 32'h0000_00E1, "R1 clear one enable");

      // R6 / R7 priority lanes and truncation
      do_wr(8'h41, 2'd0, 32'h0000_FF00);
      exp_rd(8'h40, 32'h0000_E000, "R7 0xFF reads implemented bits");
      do_wr(8'h42, 2'd0, 32'h0040_0000);
      exp_rd(8'h40, 32'h0040_E000, "R6 byte write keeps neighbour");
      do_wr(8'h42, 2'd1, 32'hA0C0_0000);
      exp_rd(8'h40, 32'hA0C0_E000, "R6 upper halfword");
      do_wr(8'h44, 2'd2, 32'h1F3F_5F7F);
      exp_rd(8'h44, 32'h0020_4060, "R7 word write truncated");

      // R3 pulse latched, R5 selection
      @(negedge clk); req_in[5] = 1;
      @(negedge clk); req_in[5] = 0;
      exp_rd(8'h08, 32'h0000_0020, "R3 pulse latched");
      exp_irq(1'b1, 5'd5, "R5 single eligible line");
      do_wr(8'h08, 2'd2, 32'h0000_00C0);
      exp_irq(1'b1, 5'd7, "R5 lowest value wins");
      do_wr(8'h47, 2'd0, 32'h2000_0000);
      exp_rd(8'h44, 32'h2020_4060, "R6 top byte lane");
      exp_irq(1'b1, 5'd6, "R5 tie goes to lower number");

      // R4 acknowledge
      ack_once();
      exp_rd(8'h0C, 32'h0000_00A0, "R4 ack clears only taken line");
      exp_irq(1'b1, 5'd7, "R4 next line offered");
      @(negedge clk); req_in[7] = 1;
      ack_once();
      exp_rd(8'h08, 32'h0000_00A0, "R4 held request re-pends");
      @(negedge clk); req_in[7] = 0;

      // R2 pending set/clear
      do_wr(8'h0C, 2'd2, 32'h0000_00FF);
      exp_rd(8'h08, 32'h0, "R2 clear all pending");
      exp_irq(1'b0, 5'd0, "R5 none eligible");
      do_wr(8'h08, 2'd2, 32'h0000_0003);
      do_wr(8'h0C, 2'd2, 32'h0000_0001);
      exp_rd(8'h08, 32'h0000_0002, "R2 clear leaves other pending");

      // R9 / R10 software trigger
      do_wr(8'h10, 2'd2, 32'd3, 1'b1);
      exp_rd(8'h08, 32'h0000_000A, "R9 trigger pends line 3");
      do_wr(8'h10, 2'd2, 32'd40, 1'b1);
      exp_rd(8'h08, 32'h0000_000A, "R9 out-of-range number ignored");
      do_wr(8'h10, 2'd2, 32'd4, 1'b0);
      exp_rd(8'h08, 32'h0000_000A, "R10 unprivileged trigger blocked");
      do_wr(8'h14, 2'd2, 32'd1);
      exp_rd(8'h14, 32'd1, "R10 cfg bit set");
      do_wr(8'h10, 2'd2, 32'd4, 1'b0);
      exp_rd(8'h08, 32'h0000_001A, "R10 unprivileged trigger allowed");
      exp_irq(1'b0, 5'd0, "R5 pending lines not enabled");

      repeat (3) @(negedge clk);
      done = 1;
      finish_run();
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         finish_run();
      end
   end

endmodule